// File: doc/BRIEF.md
# Mixed-Width Single-Clock FIFO

This block is a first-in first-out buffer on one clock whose write port and read port carry words of different widths. The wider side is one, two or four times the narrower side. The storage holds the same number of bits when seen from either side, so the read depth is the write depth scaled by the width ratio. Inside, the buffer is kept as an array of narrow slices. The write pointer and the read pointer both count in slices, and each one steps by its own side's word size.

A wide write is taken apart into narrow read words, lowest slice first. Narrow writes are packed into a wide read word, with the first one landing in the lowest slice. Each side sees its own full or empty flag and its own occupancy count, and all of these count whole words of that side only. If a wide read word has been only partly written, the reader cannot see it until its last slice arrives. A write while full or a read while empty is dropped.

Top module: `mixed_width_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, both counts are 0 and `rd_data` is 0.
- R2: The wider width is 1, 2 or 4 times the narrower one, and read depth equals write depth times `WR_W` divided by `RD_W`. Writing `WR_DEPTH` words into an empty FIFO sets `full`, and `rd_count` then reads the read depth.
- R3: When the write side is wider, the slices of one write word leave on the read port lowest byte first. Example: 32-bit write 0x4433ABCD reads back as 0xCD, 0xAB, 0x33, 0x44.
- R4: When the read side is wider, the first narrow write goes into bits [7:0] of the read word, the next into [15:8], and so on.
- R5: `full` is 1 exactly when the free space is smaller than one write word. It stays 1 after a narrow read that frees less than a write word, and it clears only once a whole write word fits.
- R6: `empty` is 1 exactly when less than one whole read word is stored. A partly filled wide read word leaves `empty` at 1 and `rd_count` at 0.
- R7: `wr_count` is the stored amount measured in whole write words, rounded down. `rd_count` is the stored amount measured in whole read words, rounded down. With a 32-bit write and an 8-bit read, one write gives `wr_count`=1 and `rd_count`=4.
- R8: A write while `full` is 1 is ignored. It changes no count or flag, and it changes no stored data.
- R9: A read while `empty` is 1 is ignored. `rd_data` and the counts keep their values.
- R10: `rd_data` is registered. It shows the word taken by an accepted read on the cycle after the read, and it holds its value on cycles with no accepted read.
- R11: Flags and counts are registered and update on the clock edge that takes the operation. A read and a write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word |
| full | output | 1 | No room for a whole write word |
| wr_count | output | clog2(WR_DEPTH+1) | Stored whole write words |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Registered read word |
| empty | output | 1 | No whole read word stored |
| rd_count | output | clog2(RD_DEPTH+1) | Stored whole read words |

## Verification
The flags and counts are registered from the next pointer values, so a pointer stepped by the wrong amount shows up as a wrong count on the very next cycle. A wrong slice address or a wrong lane order inside a word does not show in the counts. It only shows as wrong or swapped bytes on `rd_data` when that entry is read out, which can be many cycles later. For this reason a slice-level model in the bench tracks every byte and checks each read word. Two instances cover both orientations: a 32-bit write with an 8-bit read, and an 8-bit write with a 32-bit read. Both run partial-word boundaries and dropped operations, then a random mix that includes reads and writes in the same cycle.

// File: rtl/mwf_pkg.sv
package mwf_pkg;

    function automatic int unsigned narrow_of(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned wide_of(input int unsigned a, input int unsigned b);
        return (a < b) ? b : a;
    endfunction

    // Legal: widths nonzero, ratio 1, 2 or 4, depth a power of two.
    function automatic bit cfg_ok(input int unsigned wr_w, input int unsigned rd_w,
                                  input int unsigned wr_depth);
        int unsigned n;
        int unsigned r;
        if (wr_w == 0 || rd_w == 0 || wr_depth < 1) return 1'b0;
        n = narrow_of(wr_w, rd_w);
        if (wide_of(wr_w, rd_w) % n != 0) return 1'b0;
        r = wide_of(wr_w, rd_w) / n;
        if (!(r == 1 || r == 2 || r == 4)) return 1'b0;
        if ((wr_depth & (wr_depth - 1)) != 0) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/mwf_ctrl.sv
module mwf_ctrl #(
    parameter int unsigned WR_RATIO = 4,
    parameter int unsigned RD_RATIO = 1,
    parameter int unsigned SLICES   = 16,
    parameter int unsigned WC_W     = 3,
    parameter int unsigned RC_W     = 5,
    parameter int unsigned AW       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    output logic            wr_take,
    output logic            rd_take,
    output logic [AW-1:0]   waddr,
    output logic [AW-1:0]   raddr,
    output logic            full,
    output logic            empty,
    output logic [WC_W-1:0] wr_count,
    output logic [RC_W-1:0] rd_count
);
    localparam int unsigned PTR_W = AW + 1;
    localparam int unsigned WR_SH = $clog2(WR_RATIO);
    localparam int unsigned RD_SH = $clog2(RD_RATIO);
    localparam logic [PTR_W-1:0] WR_STEP = PTR_W'(WR_RATIO);
    localparam logic [PTR_W-1:0] RD_STEP = PTR_W'(RD_RATIO);
    localparam logic [PTR_W-1:0] CAP     = PTR_W'(SLICES);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic             full;
        logic             empty;
        logic [WC_W-1:0]  wcnt;
        logic [RC_W-1:0]  rcnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [PTR_W-1:0] fill_d;
    logic [PTR_W-1:0] room_d;
    logic [PTR_W-1:0] wwords_d;
    logic [PTR_W-1:0] rwords_d;

    always_comb begin
        st_d    = st_q;
        wr_take = wr_en & ~st_q.full;
        rd_take = rd_en & ~st_q.empty;
        if (wr_take) st_d.wptr = st_q.wptr + WR_STEP;
        if (rd_take) st_d.rptr = st_q.rptr + RD_STEP;
        // Occupancy in slices; the extra pointer bit separates full from empty.
        fill_d     = st_d.wptr - st_d.rptr;
        room_d     = CAP - fill_d;
        wwords_d   = fill_d >> WR_SH;
        rwords_d   = fill_d >> RD_SH;
        st_d.full  = (room_d < WR_STEP);
        st_d.empty = (fill_d < RD_STEP);
        st_d.wcnt  = wwords_d[WC_W-1:0];
        st_d.rcnt  = rwords_d[RC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr    = st_q.wptr[AW-1:0];
    assign raddr    = st_q.rptr[AW-1:0];
    assign full     = st_q.full;
    assign empty    = st_q.empty;
    assign wr_count = st_q.wcnt;
    assign rd_count = st_q.rcnt;
endmodule

// File: rtl/mwf_store.sv
module mwf_store #(
    parameter int unsigned SW       = 8,
    parameter int unsigned WR_RATIO = 4,
    parameter int unsigned RD_RATIO = 1,
    parameter int unsigned SLICES   = 16,
    parameter int unsigned AW       = 4
) (
    input  logic                   clk,
    input  logic                   wr_take,
    input  logic [AW-1:0]          waddr,
    input  logic [SW*WR_RATIO-1:0] wr_word,
    input  logic [AW-1:0]          raddr,
    output logic [SW*RD_RATIO-1:0] rd_word
);
    logic [SW-1:0] mem [SLICES];

    // Addresses are word aligned, so lane index ORs into the low bits.
    always_ff @(posedge clk) begin
        if (wr_take) begin
            for (int i = 0; i < int'(WR_RATIO); i++) begin
                mem[waddr | AW'(i)] <= wr_word[i*SW +: SW];
            end
        end
    end

    for (genvar j = 0; j < int'(RD_RATIO); j++) begin : g_rlane
        assign rd_word[j*SW +: SW] = mem[raddr | AW'(j)];
    end
endmodule

// File: rtl/mwf_rdreg.sv
module mwf_rdreg #(
    parameter int unsigned RD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_take,
    input  logic [RD_W-1:0] rd_word,
    output logic [RD_W-1:0] rd_data
);
    typedef struct packed {
        logic [RD_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_take) st_d.data = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;
endmodule

// File: rtl/mixed_width_fifo.sv
module mixed_width_fifo #(
    parameter int unsigned WR_W     = 32,
    parameter int unsigned RD_W     = 8,
    parameter int unsigned WR_DEPTH = 4,
    localparam int unsigned SW       = mwf_pkg::narrow_of(WR_W, RD_W),
    localparam int unsigned WR_RATIO = WR_W / SW,
    localparam int unsigned RD_RATIO = RD_W / SW,
    localparam int unsigned SLICES   = WR_DEPTH * WR_RATIO,
    localparam int unsigned RD_DEPTH = SLICES / RD_RATIO,
    localparam int unsigned WC_W     = $clog2(WR_DEPTH + 1),
    localparam int unsigned RC_W     = $clog2(RD_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            full,
    output logic [WC_W-1:0] wr_count,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            empty,
    output logic [RC_W-1:0] rd_count
);
    localparam int unsigned AW = (SLICES > 1) ? $clog2(SLICES) : 1;

    if (!mwf_pkg::cfg_ok(WR_W, RD_W, WR_DEPTH)) begin : g_bad_cfg
        $error("mixed_width_fifo: width ratio must be 1, 2 or 4 and depth a power of two");
    end

    logic          wr_take;
    logic          rd_take;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [RD_W-1:0] rd_word;

    mwf_ctrl #(
        .WR_RATIO(WR_RATIO), .RD_RATIO(RD_RATIO), .SLICES(SLICES),
        .WC_W(WC_W), .RC_W(RC_W), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_take(wr_take), .rd_take(rd_take), .waddr(waddr), .raddr(raddr),
        .full(full), .empty(empty), .wr_count(wr_count), .rd_count(rd_count)
    );

    mwf_store #(
        .SW(SW), .WR_RATIO(WR_RATIO), .RD_RATIO(RD_RATIO), .SLICES(SLICES), .AW(AW)
    ) u_store (
        .clk(clk), .wr_take(wr_take), .waddr(waddr), .wr_word(wr_data),
        .raddr(raddr), .rd_word(rd_word)
    );

    mwf_rdreg #(.RD_W(RD_W)) u_rdreg (
        .clk(clk), .rst_n(rst_n), .rd_take(rd_take), .rd_word(rd_word), .rd_data(rd_data)
    );
endmodule

// File: rtl/mwf_chk.sv
module mwf_chk #(
    parameter int unsigned WR_DEPTH = 4,
    parameter int unsigned RD_DEPTH = 16,
    parameter int unsigned WC_W     = 3,
    parameter int unsigned RC_W     = 5,
    parameter int unsigned RD_W     = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            full,
    input logic            empty,
    input logic [WC_W-1:0] wr_count,
    input logic [RC_W-1:0] rd_count,
    input logic [RD_W-1:0] rd_data
);
    assert_full_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> ($stable(wr_count) && $stable(rd_count) && full));

    assert_empty_read_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> ($stable(rd_data) && $stable(rd_count) && empty));

    assert_empty_tracks_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (rd_count == '0));

    assert_full_at_last_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(wr_count) == WR_DEPTH) |-> full);

    assert_full_near_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (32'(wr_count) + 1 >= WR_DEPTH));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_count) <= RD_DEPTH) && (32'(wr_count) <= WR_DEPTH));
endmodule

bind mixed_width_fifo mwf_chk #(
    .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .WC_W(WC_W), .RC_W(RC_W), .RD_W(RD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
    .wr_count(wr_count), .rd_count(rd_count), .rd_data(rd_data)
);

// File: tb/mixed_width_fifo_tb.sv
module mixed_width_fifo_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Instance A: 32-bit write, 8-bit read, 4 write words (16 slices)
    logic        a_we = 0, a_re = 0;
    logic [31:0] a_wd = '0;
    logic        a_full, a_empty;
    logic [2:0]  a_wc;
    logic [4:0]  a_rc;
    logic [7:0]  a_rd;

    // Instance B: 8-bit write, 32-bit read, 16 write words (16 slices)
    logic        b_we = 0, b_re = 0;
    logic [7:0]  b_wd = '0;
    logic        b_full, b_empty;
    logic [4:0]  b_wc;
    logic [2:0]  b_rc;
    logic [31:0] b_rd;

    mixed_width_fifo #(.WR_W(32), .RD_W(8), .WR_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(a_we), .wr_data(a_wd), .full(a_full),
        .wr_count(a_wc), .rd_en(a_re), .rd_data(a_rd), .empty(a_empty), .rd_count(a_rc)
    );

    mixed_width_fifo #(.WR_W(8), .RD_W(32), .WR_DEPTH(16)) u_dut_pk (
        .clk(clk), .rst_n(rst_n), .wr_en(b_we), .wr_data(b_wd), .full(b_full),
        .wr_count(b_wc), .rd_en(b_re), .rd_data(b_rd), .empty(b_empty), .rd_count(b_rc)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0]  qa[$];
    logic [7:0]  qb[$];
    logic [7:0]  exp_a_rd = '0;
    logic [31:0] exp_b_rd = '0;

    function automatic bit f_full(int fill, int wr_ratio);
        return (16 - fill) < wr_ratio;
    endfunction
    function automatic bit f_empty(int fill, int rd_ratio);
        return fill < rd_ratio;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "a full",  32'(a_full),  32'(f_full(qa.size(), 4)));
        chk(tag, "a empty", 32'(a_empty), 32'(f_empty(qa.size(), 1)));
        chk(tag, "a wr_count", 32'(a_wc), 32'(qa.size() / 4));
        chk(tag, "a rd_count", 32'(a_rc), 32'(qa.size()));
        chk(tag, "a rd_data", 32'(a_rd), 32'(exp_a_rd));
        chk(tag, "b full",  32'(b_full),  32'(f_full(qb.size(), 1)));
        chk(tag, "b empty", 32'(b_empty), 32'(f_empty(qb.size(), 4)));
        chk(tag, "b wr_count", 32'(b_wc), 32'(qb.size()));
        chk(tag, "b rd_count", 32'(b_rc), 32'(qb.size() / 4));
        chk(tag, "b rd_data", b_rd, exp_b_rd);
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic cyc(input logic awe, input logic are, input logic [31:0] awd,
                       input logic bwe, input logic bre, input logic [7:0] bwd,
                       input string tag);
        bit a_wt, a_rt, b_wt, b_rt;
        a_wt = awe && !f_full(qa.size(), 4);
        a_rt = are && !f_empty(qa.size(), 1);
        b_wt = bwe && !f_full(qb.size(), 1);
        b_rt = bre && !f_empty(qb.size(), 4);
        a_we = awe; a_re = are; a_wd = awd;
        b_we = bwe; b_re = bre; b_wd = bwd;
        @(posedge clk);
        @(negedge clk);
        if (a_rt) exp_a_rd = qa.pop_front();
        if (a_wt) for (int k = 0; k < 4; k++) qa.push_back(awd[k*8 +: 8]);
        if (b_rt) for (int k = 0; k < 4; k++) exp_b_rd[k*8 +: 8] = qb.pop_front();
        if (b_wt) qb.push_back(bwd);
        a_we = 0; a_re = 0; b_we = 0; b_re = 0;
        compare_all(tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R7 / R3: one wide write, then four narrow reads
        cyc(1, 0, 32'h4433ABCD, 0, 0, 8'h00, "R7");
        chk("R7", "a wr_count literal", 32'(a_wc), 32'd1);
        chk("R7", "a rd_count literal", 32'(a_rc), 32'd4);
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R3");
        chk("R3", "first slice", 32'(a_rd), 32'hCD);
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R3");
        chk("R3", "second slice", 32'(a_rd), 32'hAB);
        cyc(0, 0, 32'h0, 0, 0, 8'h00, "R10");
        chk("R10", "hold", 32'(a_rd), 32'hAB);
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R3");
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R3");
        chk("R3", "fourth slice", 32'(a_rd), 32'h44);

        // R9: read while empty
        cyc(0, 1, 32'h0, 0, 1, 8'h00, "R9");
        chk("R9", "a rd_data held", 32'(a_rd), 32'h44);

        // R2 / R8 / R5 on A
        for (int i = 0; i < 4; i++) cyc(1, 0, 32'h1000_0000 * i + 32'h00030201 + i, 0, 0, 8'h00, "R2");
        chk("R2", "a full literal", 32'(a_full), 32'd1);
        chk("R2", "a rd_count literal", 32'(a_rc), 32'd16);
        cyc(1, 0, 32'hDEADBEEF, 0, 0, 8'h00, "R8");
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R5");
        chk("R5", "full after one slice out", 32'(a_full), 32'd1);
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R5");
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R5");
        cyc(0, 1, 32'h0, 0, 0, 8'h00, "R5");
        chk("R5", "full cleared at word room", 32'(a_full), 32'd0);
        for (int i = 0; i < 12; i++) cyc(0, 1, 32'h0, 0, 0, 8'h00, "R8");

        // R6 / R4 on B
        cyc(0, 0, 32'h0, 1, 0, 8'hA1, "R6");
        cyc(0, 0, 32'h0, 1, 0, 8'hB2, "R6");
        cyc(0, 0, 32'h0, 1, 1, 8'hC3, "R6");
        chk("R6", "b empty partial", 32'(b_empty), 32'd1);
        chk("R6", "b rd_count partial", 32'(b_rc), 32'd0);
        cyc(0, 0, 32'h0, 1, 0, 8'hD4, "R6");
        chk("R6", "b empty whole", 32'(b_empty), 32'd0);
        cyc(0, 0, 32'h0, 0, 1, 8'h00, "R4");
        chk("R4", "packed word", b_rd, 32'hD4C3B2A1);

        // B full and ignored write
        for (int i = 0; i < 16; i++) cyc(0, 0, 32'h0, 1, 0, 8'(8'h10 + i), "R2");
        chk("R2", "b full literal", 32'(b_full), 32'd1);
        cyc(0, 0, 32'h0, 1, 0, 8'hEE, "R8");
        for (int i = 0; i < 4; i++) cyc(0, 0, 32'h0, 0, 1, 8'h00, "R8");

        // Random mix with simultaneous operations
        for (int i = 0; i < 3000; i++) begin
            cyc(1'($urandom % 2), 1'($urandom % 2), $urandom,
                1'(($urandom % 4) != 0), 1'(($urandom % 3) == 0), 8'($urandom), "R11");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule